// File: doc/BRIEF.md
# Serial Flash Sector Erase Sequencer

This block runs a complete sector erase on a serial flash or EEPROM that is attached over SPI. Software first writes a two-bit sector number into the sector-select register at offset 91h. It then writes the byte 52h into the command register at offset 90h. The sequencer then runs the whole handshake with no further help from software. It sends a write-enable command. It then reads the device status as often as needed, until the device is ready and write-enabled. Last, it sends the erase opcode followed by a 24-bit address. In that address only the two sector bits can be non-zero.

The serial side uses SPI mode 0. The clock idles low, the device samples on the rising edge, and data changes on the falling edge. The clock runs at the system clock divided by `2*HALF_DIV`. Between commands, chip select goes high for at least one full SPI clock period. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `sect_erase_seq`

## Requirements
- R1: A write of 52h to offset 90h while the block is idle starts a sequence. A write of any other value to offset 90h, or a write of 52h to any other offset, starts nothing and produces no SPI traffic.
- R2: The sector-select register sits at offset 91h, with sector bit 1 in data bit 1 and sector bit 0 in data bit 0. Its value is captured when a sequence starts. A write to it during a running sequence does not change that sequence's erase address.
- R3: The first frame of every sequence is the write-enable opcode 06h, sent as exactly 8 SPI clocks.
- R4: After write-enable, the block sends read-status frames. Each frame is opcode 05h plus 8 more clocks that read the status byte. In that byte, bit 0 is the not-ready flag and bit 1 is the write-enable flag. The block repeats these frames until a status byte shows bit 0 = 0 and bit 1 = 1. The erase frame is never sent before that happens.
- R5: The erase frame is 32 clocks under a single chip-select assertion. It carries opcode 52h, then the address bytes with the most significant byte first. Address bit 16 is sector bit 1, address bit 15 is sector bit 0, and all other address bits are 0. Every byte is sent MSB first.
- R6: The SPI clock is low whenever chip select is high. While chip select is low, each clock level lasts exactly HALF_DIV system clocks.
- R7: Between two frames, chip select stays high for at least 2*HALF_DIV system clocks.
- R8: Busy rises in the cycle after the accepted start write. Chip select rises at the end of the erase frame. Exactly 2*HALF_DIV+1 clocks after that, done pulses high for one cycle, and busy falls in that same cycle.
- R9: A write of 52h to offset 90h while busy is high is ignored. No extra frames are sent and the sequence is not restarted.
- R10: A start write presented in the cycle in which done is high is accepted and starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_off_i | input | 8 | Register offset of the write |
| reg_wdata_i | input | 8 | Register write data |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_sck_o | output | 1 | SPI serial clock |
| spi_mosi_o | output | 1 | SPI data towards the device |
| spi_miso_i | input | 1 | SPI data from the device |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
The end of one sequence and the acceptance of the next can fall in the same cycle. The bench provokes this by waiting for done to be observed and then presenting a start write immediately. A reference model, stepped once per clock, must then show busy rising again in the next cycle and a fresh write-enable frame appearing. The bench also provokes a second overlap: a new sector value and a repeated start write both land while a sequence is running. Judgement comes from the captured erase frame, which must carry the old sector bits, and from the frame queue, which must show no extra frames.

// File: rtl/sect_erase_pkg.sv
package sect_erase_pkg;
    localparam int          FRAME_W       = 32;
    localparam logic [7:0]  OP_WREN       = 8'h06;
    localparam logic [7:0]  OP_RDSR       = 8'h05;
    localparam int          STAT_RDYN_BIT = 0;
    localparam int          STAT_WEN_BIT  = 1;

    typedef enum logic [1:0] {SQ_IDLE, SQ_WREN, SQ_POLL, SQ_ERASE} seq_st_e;
    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} shf_st_e;
endpackage

// File: rtl/flash_status_decode.sv
module flash_status_decode
    import sect_erase_pkg::*;
(
    input  logic [1:0] stat_i,
    output logic       ok_o
);
    // device is ready (not-ready flag clear) and write latch is set
    assign ok_o = !stat_i[STAT_RDYN_BIT] && stat_i[STAT_WEN_BIT];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import sect_erase_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int FW       = FRAME_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go_i,
    input  logic [FW-1:0]              frame_i,
    input  logic [$clog2(FW+1)-1:0]    nbits_i,
    input  logic                       miso_i,
    output logic                       cs_n_o,
    output logic                       sck_o,
    output logic                       mosi_o,
    output logic [1:0]                 rx_o,
    output logic                       done_o
);
    localparam int CNT_W = $clog2(FW + 1);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int GAP_W = $clog2(2 * HALF_DIV + 1);

    typedef struct packed {
        shf_st_e          st;
        logic             cs_n;
        logic             sck;
        logic [FW-1:0]    sh;
        logic [CNT_W-1:0] bits_left;
        logic [DIV_W-1:0] div;
        logic [GAP_W-1:0] gap;
        logic [1:0]       rx;
        logic             done;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            SH_IDLE: begin
                if (go_i) begin
                    d.st        = SH_SHIFT;
                    d.cs_n      = 1'b0;
                    d.sck       = 1'b0;
                    d.sh        = frame_i;
                    d.bits_left = nbits_i;
                    d.div       = '0;
                end
            end
            SH_SHIFT: begin
                if (q.div == DIV_W'(HALF_DIV - 1)) begin
                    d.div = '0;
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        d.rx  = {q.rx[0], miso_i};
                    end else begin
                        d.sck       = 1'b0;
                        d.sh        = {q.sh[FW-2:0], 1'b0};
                        d.bits_left = q.bits_left - CNT_W'(1);
                        if (q.bits_left == CNT_W'(1)) begin
                            d.st   = SH_GAP;
                            d.cs_n = 1'b1;
                            d.gap  = '0;
                        end
                    end
                end else begin
                    d.div = q.div + DIV_W'(1);
                end
            end
            SH_GAP: begin
                if (q.gap == GAP_W'(2 * HALF_DIV - 1)) begin
                    d.st   = SH_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.gap = q.gap + GAP_W'(1);
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= SH_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o = q.cs_n;
    assign sck_o  = q.sck;
    assign mosi_o = !q.cs_n && q.sh[FW-1];
    assign rx_o   = q.rx;
    assign done_o = q.done;

    // R6: clock parked low while the device is deselected
    assert_sck_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !q.sck);
    // R7: a deselect lasts longer than one cycle
    assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |=> q.cs_n);
endmodule

// File: rtl/sect_erase_seq.sv
module sect_erase_seq
    import sect_erase_pkg::*;
#(
    parameter int         HALF_DIV = 2,
    parameter logic [7:0] CMD_OFF  = 8'h90,
    parameter logic [7:0] SEC_OFF  = 8'h91,
    parameter logic [7:0] ERASE_OP = 8'h52
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_off_i,
    input  logic [7:0] reg_wdata_i,
    output logic       spi_cs_n_o,
    output logic       spi_sck_o,
    output logic       spi_mosi_o,
    input  logic       spi_miso_i,
    output logic       busy_o,
    output logic       done_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        seq_st_e            st;
        logic [1:0]         sec;
        logic [1:0]         sec_lat;
        logic               go;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   nbits;
        logic               done;
    } seq_t;

    seq_t q, d;

    logic       shf_done;
    logic [1:0] shf_rx;
    logic       stat_ok;
    logic       start_req;

    assign start_req = reg_wr_i && (reg_off_i == CMD_OFF) && (reg_wdata_i == ERASE_OP);

    spi_frame_shifter #(.HALF_DIV(HALF_DIV), .FW(FRAME_W)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (q.go),
        .frame_i (q.frame),
        .nbits_i (q.nbits),
        .miso_i  (spi_miso_i),
        .cs_n_o  (spi_cs_n_o),
        .sck_o   (spi_sck_o),
        .mosi_o  (spi_mosi_o),
        .rx_o    (shf_rx),
        .done_o  (shf_done)
    );

    flash_status_decode i_stat (
        .stat_i (shf_rx),
        .ok_o   (stat_ok)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        if (reg_wr_i && (reg_off_i == SEC_OFF)) begin
            d.sec = reg_wdata_i[1:0];
        end
        case (q.st)
            SQ_IDLE: begin
                if (start_req) begin
                    d.st      = SQ_WREN;
                    d.sec_lat = q.sec;
                    d.go      = 1'b1;
                    d.frame   = {OP_WREN, 24'h0};
                    d.nbits   = CNT_W'(8);
                end
            end
            SQ_WREN: begin
                if (shf_done) begin
                    d.st    = SQ_POLL;
                    d.go    = 1'b1;
                    d.frame = {OP_RDSR, 24'h0};
                    d.nbits = CNT_W'(16);
                end
            end
            SQ_POLL: begin
                if (shf_done) begin
                    d.go = 1'b1;
                    if (stat_ok) begin
                        d.st    = SQ_ERASE;
                        d.frame = {ERASE_OP, 7'b0, q.sec_lat, 15'b0};
                        d.nbits = CNT_W'(32);
                    end
                end
            end
            SQ_ERASE: begin
                if (shf_done) begin
                    d.st   = SQ_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != SQ_IDLE);
    assign done_o = q.done;

    // R1: busy only ever rises after a valid start write
    assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_req));
    // R4: erase phase is entered only after a good status byte
    assert_erase_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == SQ_ERASE) |-> $past(stat_ok));
    // R2: captured sector does not move while a sequence runs
    assert_sector_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SQ_IDLE) |=> $stable(q.sec_lat));
    // R8: done is a single-cycle pulse that follows the erase phase
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(q.st == SQ_ERASE));
endmodule

// File: tb/test_sect_erase_seq.sv
module test_sect_erase_seq;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_off = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       cs_n, sck, mosi, busy, done;
    logic       miso = 1'b0;

    always #4 clk = ~clk;

    sect_erase_seq #(.HALF_DIV(HALF)) i_sect_erase_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_off_i   (reg_off),
        .reg_wdata_i (reg_wdata),
        .spi_cs_n_o  (cs_n),
        .spi_sck_o   (sck),
        .spi_mosi_o  (mosi),
        .spi_miso_i  (miso),
        .busy_o      (busy),
        .done_o      (done)
    );

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    // device and reference model state
    int unsigned exp_bits[$];
    logic [31:0] exp_val[$];
    int          notready_polls = 0;
    int          wen_delay = 0;
    int          polls_seen = 0;
    bit          dev_wen = 1'b0;
    bit          busy_ref = 1'b0;
    bit          done_ref = 1'b0;
    int          fin_cnt = 0;
    logic [31:0] last_erase = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] off, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push_seq(input logic [1:0] sec, input int nr, input int wd);
        int polls;
        notready_polls = nr;
        wen_delay = wd;
        polls_seen = 0;
        polls = ((nr > wd) ? nr : wd) + 1;
        exp_bits.push_back(8);  exp_val.push_back(32'h0600_0000);
        for (int i = 0; i < polls; i++) begin
            exp_bits.push_back(16); exp_val.push_back(32'h0500_0000);
        end
        exp_bits.push_back(32); exp_val.push_back({8'h52, 7'b0, sec, 15'b0});
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy === 1'b1);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // per-clock reference model and serial device
    logic        cs_prev = 1'b1;
    logic        sck_prev = 1'b0;
    logic [31:0] rx_word = '0;
    int          rx_n = 0;
    int          since_edge = 0;
    int          gap_len = 1000;
    logic [7:0]  op_byte = '0;
    logic [7:0]  stat = '0;

    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #2;
            done_ref = 1'b0;
            if (!busy_ref && reg_wr && reg_off == 8'h90 && reg_wdata == 8'h52) begin
                busy_ref = 1'b1;
            end else if (fin_cnt > 0) begin
                fin_cnt--;
                if (fin_cnt == 0) begin
                    busy_ref = 1'b0;
                    done_ref = 1'b1;
                end
            end
            chk(busy === busy_ref, "R8 busy per cycle", {31'b0, busy}, {31'b0, busy_ref});
            chk(done === done_ref, "R8 done per cycle", {31'b0, done}, {31'b0, done_ref});
            if (!busy_ref) chk(cs_n === 1'b1, "R1 no traffic when idle", {31'b0, cs_n}, 32'd1);

            if (cs_prev && !cs_n) begin
                chk(gap_len >= 2 * HALF, "R7 deselect gap", gap_len, 2 * HALF);
                rx_word = '0; rx_n = 0; since_edge = 0; op_byte = '0;
            end
            if (!cs_prev && cs_n) begin
                gap_len = 0;
                if (exp_bits.size() == 0) begin
                    chk(1'b0, "R9 unexpected frame", rx_word, 32'h0);
                end else begin
                    int unsigned eb;
                    logic [31:0] ev, got;
                    string tag;
                    eb = exp_bits.pop_front();
                    ev = exp_val.pop_front();
                    got = rx_word << (32 - rx_n);
                    tag = (ev[31:24] == 8'h06) ? "R3 write-enable frame" :
                          (ev[31:24] == 8'h05) ? "R4 status frame" : "R5 erase frame";
                    chk(rx_n == eb, {tag, " length"}, rx_n, eb);
                    chk(got == ev, {tag, " content"}, got, ev);
                end
                if (op_byte == 8'h06) dev_wen = 1'b1;
                else if (op_byte == 8'h05) polls_seen++;
                else if (op_byte == 8'h52) begin
                    chk(dev_wen && polls_seen > 0, "R4 erase only after good poll",
                        {31'b0, dev_wen}, 32'd1);
                    last_erase = rx_word;
                    dev_wen = 1'b0;
                    fin_cnt = 2 * HALF + 1;
                end
            end

            if (!cs_n) begin
                if (sck !== sck_prev) begin
                    chk(since_edge == HALF, "R6 half period", since_edge, HALF);
                    since_edge = 0;
                    if (sck) begin
                        rx_word = {rx_word[30:0], mosi};
                        rx_n++;
                        if (rx_n == 8) op_byte = rx_word[7:0];
                    end else if (op_byte == 8'h05 && rx_n >= 8 && rx_n < 16) begin
                        stat = {6'b0, dev_wen && (polls_seen >= wen_delay),
                                polls_seen < notready_polls};
                        miso = stat[15 - rx_n];
                    end
                end
                since_edge++;
            end else begin
                chk(sck === 1'b0, "R6 sck low while deselected", {31'b0, sck}, 32'd0);
                gap_len++;
            end
            cs_prev = cs_n;
            sck_prev = sck;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(cs_n === 1'b1, "R6 reset cs", {31'b0, cs_n}, 32'd1);
        chk(sck === 1'b0, "R6 reset sck", {31'b0, sck}, 32'd0);
        chk(busy === 1'b0 && done === 1'b0, "R8 reset flags", {30'b0, busy, done}, 32'd0);

        // R1: writes that must not start anything
        wr_reg(8'h90, 8'h20);
        wr_reg(8'h91, 8'h52);
        wr_reg(8'h92, 8'h52);
        repeat (30) @(negedge clk);
        chk(busy === 1'b0, "R1 ignored writes keep idle", {31'b0, busy}, 32'd0);

        // R3 R5: sector 3, ready immediately
        wr_reg(8'h91, 8'h03);
        push_seq(2'b11, 0, 0);
        wr_reg(8'h90, 8'h52);
        wait_idle();

        // R4: several not-ready polls, sector 1
        wr_reg(8'h91, 8'h01);
        push_seq(2'b01, 3, 0);
        wr_reg(8'h90, 8'h52);
        wait_idle();

        // R4 R2 R9: write latch reported late; sector and start rewritten mid-run
        wr_reg(8'h91, 8'h02);
        push_seq(2'b10, 0, 2);
        wr_reg(8'h90, 8'h52);
        wr_reg(8'h91, 8'h01);
        wr_reg(8'h90, 8'h52);
        wait_idle();
        chk(last_erase[16:15] == 2'b10, "R2 sector captured at start", last_erase[16:15], 2'b10);
        repeat (40) @(negedge clk);
        chk(busy === 1'b0 && exp_bits.size() == 0, "R9 no restart from busy write",
            exp_bits.size(), 0);

        // R10: start presented in the done cycle
        wr_reg(8'h91, 8'h00);
        push_seq(2'b00, 1, 0);
        wr_reg(8'h90, 8'h52);
        while (done !== 1'b1) @(negedge clk);
        push_seq(2'b00, 0, 0);
        reg_wr = 1'b1; reg_off = 8'h90; reg_wdata = 8'h52;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy === 1'b1, "R10 start in done cycle accepted", {31'b0, busy}, 32'd1);
        wait_idle();

        chk(exp_bits.size() == 0, "R5 all expected frames seen", exp_bits.size(), 0);
        finish_run();
    end
endmodule